// File: doc/BRIEF.md
# DRAM Refresh Counter Test Sequencer

This block drives the control, address and data pins of an asynchronous DRAM through a self-check of the DRAM's on-chip refresh row counter. After a start pulse it walks the whole test with no further input. It first issues a short burst of RAS-only refreshes. It then writes a background value to every row at one column, using explicit row addresses. Next it runs one counter-addressed read-modify-write cycle per row. Each of these cycles checks the background and writes its complement. Last, it reads every row back with explicit addresses. The whole test is then run a second time with the data inverted.

Because the middle phase never puts a row address on the pins, the test passes only if the DRAM's internal counter visits every row exactly once. If a row is skipped or visited twice, a check in the middle or final phase sees the wrong value. The sequencer then reports the failing row and the phase it failed in. All DRAM timing is counted in whole clock cycles. An input sets the number of precharge clocks between memory cycles.

Top module: `dram_cbr_test_seq`

## Requirements
- R1: After a reset, RAS, CAS, WE and OE are all high, the data bus is not driven, and done and fail are low. With no start pulse, the pins stay in that state.
- R2: A run opens with exactly INIT_CYCLES memory cycles (default 8) in which RAS falls while CAS stays high.
- R3: The fill phase performs 2^ROW_BITS early-write cycles (1024 by default) with explicit row addresses. Each column strobe carries the `col` input on the address pins.
- R4: The counter phase performs 2^ROW_BITS cycles. In each one, CAS falls before RAS, rises while RAS is low, and then falls a second time with `col` on the address pins. OE then goes low so the background value can be checked, and WE then goes low to write its complement.
- R5: The verify phase performs 2^ROW_BITS normal read cycles, each checking that the row holds the complement of the background.
- R6: The first pass uses background 0. The second pass repeats the fill, counter and verify phases with background 1. This gives exactly 2^ROW_BITS fill writes of all ones per run.
- R7: Every written word has all DQ bits equal. A read fails if any single bit differs from the expected value.
- R8: On the first failed check, the sequencer sets fail, completes the current memory cycle, issues no further cycles, and raises done. fail_row holds the row: the explicit row in the verify phase, or the count of earlier counter cycles in that pass. fail_phase holds {pass, phase}, where pass 0 is the first pass, phase 2'b10 is the counter phase and 2'b11 is the verify phase.
- R9: Between memory cycles, RAS and CAS are high for at least max(cyc_gap,1) clocks. Between two normal or RAS-only cycles, RAS is high for exactly that many clocks.
- R10: done stays high, and the fail outputs hold their values, until the next start. A start pulse while a run is active has no effect.
- R11: The data bus is driven only while OE is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock pulse that begins a run |
| col | input | COL_BITS | Column used by every access; hold it stable during a run |
| cyc_gap | input | GAP_W | Precharge clocks between memory cycles (0 is treated as 1) |
| done | output | 1 | Run finished |
| fail | output | 1 | A check failed |
| fail_row | output | ROW_BITS | Row of the first failed check |
| fail_phase | output | 3 | {pass, phase} of the first failed check |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ADDR_W | Multiplexed row/column address |
| dq_out | output | DQ_W | Write data |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DQ_W | Read data from the DRAM |

## Verification
Suppose the phase sequencer's row or pass state goes wrong. That shows at the ports as a wrong count of cycles of a given kind, or as a fill-write value that does not match the pass. The bench model counts these per run, so the error is visible at done. A fault in the cycle engine breaks the strobe pattern within a single memory cycle, and the bound checker flags it on the next clock. A wrong captured tag shows as a wrong fail_row or fail_phase. Several injected DRAM faults (a skipped counter step, stuck bits, a lost write in the second pass) each have a known first failing row and phase, and a known number of completed cycles.

// File: rtl/dram_cbr_pkg.sv
// Shared types for the refresh counter test sequencer.
// Assumes nothing beyond the SystemVerilog enum encodings given here;
// the phase code is visible at the ports through fail_phase.
package dram_cbr_pkg;

    // Test phases; the numeric value is reported in fail_phase[1:0].
    typedef enum logic [1:0] {
        PH_INIT   = 2'd0,
        PH_FILL   = 2'd1,
        PH_CBR    = 2'd2,
        PH_VERIFY = 2'd3
    } phase_t;

    // Kind of memory cycle the engine is asked to perform.
    typedef enum logic [1:0] {
        CK_REFRESH = 2'd0,
        CK_WRITE   = 2'd1,
        CK_READ    = 2'd2,
        CK_CBR     = 2'd3
    } cyc_kind_t;

    // Cycle engine steps; each step lasts one clock except E_PRE.
    typedef enum logic [3:0] {
        E_IDLE, E_RAS, E_RFH, E_ACOL, E_CASL, E_HOLD,
        E_CB1, E_CB2, E_CB3, E_CB4, E_CB5, E_CB6, E_CB7,
        E_PRE
    } eng_state_t;

    // Top-level run state.
    typedef enum logic [1:0] {
        T_IDLE, T_RUN, T_DRAIN, T_DONE
    } run_state_t;

endpackage

// File: rtl/dram_cyc_engine.sv
// Memory cycle engine: turns one command (kind, row, data bits, tag) into
// the pin waveform of a single DRAM cycle, then holds RAS/CAS high for
// the precharge count. A new command is taken only when ready is high;
// ready rises in the last precharge clock so cycles chain with no gap.
// Assumes col and cyc_gap are stable while a run is active.
module dram_cyc_engine
    import dram_cbr_pkg::*;
#(
    parameter int ROW_BITS = 10,
    parameter int COL_BITS = 10,
    parameter int ADDR_W   = 10,
    parameter int DQ_W     = 16,
    parameter int GAP_W    = 4,
    parameter int TAG_W    = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  cyc_kind_t           kind,
    input  logic [ROW_BITS-1:0] row,
    input  logic                wr_bit,
    input  logic                exp_bit,
    input  logic [TAG_W-1:0]    tag,
    input  logic [COL_BITS-1:0] col,
    input  logic [GAP_W-1:0]    cyc_gap,
    output logic                ready,
    output logic                idle,
    output logic                rd_strobe,
    output logic                rd_exp,
    output logic [TAG_W-1:0]    cur_tag,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic                oe_n,
    output logic [ADDR_W-1:0]   addr,
    output logic [DQ_W-1:0]     dq_out,
    output logic                dq_oe
);

    eng_state_t          state_q, state_d;
    logic [GAP_W-1:0]    cnt_q;
    cyc_kind_t           kind_q;
    logic [ROW_BITS-1:0] row_q;
    logic                wr_q, exp_q;
    logic [TAG_W-1:0]    tag_q;
    logic [GAP_W-1:0]    gap_eff, pre_load;
    logic                take, is_write, is_read;
    logic                ras_low, cas_low, col_on_bus;

    // Effective precharge length: a zero setting still gives one clock.
    always_comb begin
        gap_eff  = (cyc_gap == '0) ? GAP_W'(1) : cyc_gap;
        pre_load = gap_eff - GAP_W'(1);
    end

    assign ready = (state_q == E_IDLE) || (state_q == E_PRE && cnt_q == '0);
    assign idle  = (state_q == E_IDLE);
    assign take  = go && ready;

    // Next-step selection for the cycle being performed.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_IDLE, E_PRE: begin
                if (take)
                    state_d = (kind == CK_CBR) ? E_CB1 : E_RAS;
                else if (ready)
                    state_d = E_IDLE;
            end
            E_RAS:  state_d = (kind_q == CK_REFRESH) ? E_RFH : E_ACOL;
            E_RFH:  state_d = E_PRE;
            E_ACOL: state_d = E_CASL;
            E_CASL: state_d = E_HOLD;
            E_HOLD: state_d = E_PRE;
            E_CB1:  state_d = E_CB2;
            E_CB2:  state_d = E_CB3;
            E_CB3:  state_d = E_CB4;
            E_CB4:  state_d = E_CB5;
            E_CB5:  state_d = E_CB6;
            E_CB6:  state_d = E_CB7;
            E_CB7:  state_d = E_PRE;
            default: state_d = E_IDLE;
        endcase
    end

    // Step register, precharge counter and latched command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= E_IDLE;
            cnt_q   <= '0;
            kind_q  <= CK_REFRESH;
            row_q   <= '0;
            wr_q    <= 1'b0;
            exp_q   <= 1'b0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                kind_q <= kind;
                row_q  <= row;
                wr_q   <= wr_bit;
                exp_q  <= exp_bit;
                tag_q  <= tag;
            end
            if (state_d == E_PRE && state_q != E_PRE)
                cnt_q <= pre_load;
            else if (state_q == E_PRE && cnt_q != '0)
                cnt_q <= cnt_q - GAP_W'(1);
        end
    end

    // Strobe levels decoded from the current step.
    always_comb begin
        is_write   = (kind_q == CK_WRITE);
        is_read    = (kind_q == CK_READ);
        ras_low    = state_q inside {E_RAS, E_RFH, E_ACOL, E_CASL, E_HOLD,
                                     E_CB2, E_CB3, E_CB4, E_CB5, E_CB6, E_CB7};
        cas_low    = state_q inside {E_CASL, E_HOLD, E_CB1, E_CB2,
                                     E_CB4, E_CB5, E_CB6, E_CB7};
        col_on_bus = state_q inside {E_ACOL, E_CASL, E_HOLD,
                                     E_CB3, E_CB4, E_CB5, E_CB6, E_CB7};
    end

    // Pin drive: address mux, write enable, output enable, data.
    always_comb begin
        ras_n = !ras_low;
        cas_n = !cas_low;
        if (state_q == E_RAS || state_q == E_RFH)
            addr = ADDR_W'(row_q);
        else if (col_on_bus)
            addr = ADDR_W'(col);
        else
            addr = '0;
        we_n   = !(((state_q == E_ACOL || state_q == E_CASL) && is_write) ||
                   state_q == E_CB6 || state_q == E_CB7);
        oe_n   = !(((state_q == E_CASL || state_q == E_HOLD) && is_read) ||
                   state_q == E_CB4 || state_q == E_CB5);
        dq_oe  = !we_n;
        dq_out = {DQ_W{wr_q}};
    end

    // Read data is valid in the last clock that OE is low.
    assign rd_strobe = (state_q == E_HOLD && is_read) || (state_q == E_CB5);
    assign rd_exp    = exp_q;
    assign cur_tag   = tag_q;

endmodule

// File: rtl/dram_dq_compare.sv
// Read checker: compares every DQ bit with the expected pattern bit while
// the engine's read strobe is high. Purely combinational; assumes the
// test pattern is the same on all bits.
module dram_dq_compare #(
    parameter int DQ_W = 16
) (
    input  logic            strobe,
    input  logic            exp_bit,
    input  logic [DQ_W-1:0] dq,
    output logic            mismatch
);

    logic [DQ_W-1:0] bit_err;

    // One XOR per data bit against the expected level.
    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
        assign bit_err[b] = dq[b] ^ exp_bit;
    end

    assign mismatch = strobe && (|bit_err);

endmodule

// File: rtl/dram_cbr_test_seq.sv
// Refresh counter test sequencer (top). Steps through counter init, fill,
// counter-addressed read-modify-write and verify, twice with opposite
// backgrounds, and stops on the first mismatch. Assumes INIT_CYCLES fits
// in ROW_BITS and that col and cyc_gap stay stable for a whole run.
module dram_cbr_test_seq
    import dram_cbr_pkg::*;
#(
    parameter  int ROW_BITS    = 10,
    parameter  int COL_BITS    = 10,
    parameter  int DQ_W        = 16,
    parameter  int GAP_W       = 4,
    parameter  int INIT_CYCLES = 8,
    localparam int ADDR_W      = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [COL_BITS-1:0] col,
    input  logic [GAP_W-1:0]    cyc_gap,
    output logic                done,
    output logic                fail,
    output logic [ROW_BITS-1:0] fail_row,
    output logic [2:0]          fail_phase,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic                oe_n,
    output logic [ADDR_W-1:0]   addr,
    output logic [DQ_W-1:0]     dq_out,
    output logic                dq_oe,
    input  logic [DQ_W-1:0]     dq_in
);

    localparam int INIT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam int TAG_W  = ROW_BITS + 3;

    run_state_t          run_q;
    phase_t              phase_q;
    logic                pass_q;
    logic [ROW_BITS-1:0] row_q;
    logic [INIT_W-1:0]   init_q;
    logic                done_q, fail_q;
    logic [ROW_BITS-1:0] frow_q;
    logic [2:0]          fph_q;

    cyc_kind_t           cmd_kind;
    logic [ROW_BITS-1:0] cmd_row;
    logic                cmd_wr, cmd_exp;
    logic [TAG_W-1:0]    cmd_tag, cur_tag;
    logic                go, ready, eng_idle, accept;
    logic                rd_strobe, rd_exp, mismatch;
    logic                row_last, init_last;

    // Command for the current position in the test.
    always_comb begin
        cmd_kind = CK_READ;
        cmd_row  = row_q;
        cmd_wr   = pass_q;
        cmd_exp  = !pass_q;
        unique case (phase_q)
            PH_INIT:   begin cmd_kind = CK_REFRESH; cmd_row = ROW_BITS'(init_q); end
            PH_FILL:   begin cmd_kind = CK_WRITE;   cmd_wr  = pass_q; end
            PH_CBR:    begin cmd_kind = CK_CBR; cmd_exp = pass_q; cmd_wr = !pass_q; end
            default:   begin cmd_kind = CK_READ;    cmd_exp = !pass_q; end
        endcase
        cmd_tag = {pass_q, phase_q, row_q};
    end

    assign go        = (run_q == T_RUN);
    assign accept    = go && ready;
    assign row_last  = &row_q;
    assign init_last = (init_q == INIT_W'(INIT_CYCLES - 1));

    dram_cyc_engine #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .ADDR_W   (ADDR_W),
        .DQ_W     (DQ_W),
        .GAP_W    (GAP_W),
        .TAG_W    (TAG_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .kind      (cmd_kind),
        .row       (cmd_row),
        .wr_bit    (cmd_wr),
        .exp_bit   (cmd_exp),
        .tag       (cmd_tag),
        .col       (col),
        .cyc_gap   (cyc_gap),
        .ready     (ready),
        .idle      (eng_idle),
        .rd_strobe (rd_strobe),
        .rd_exp    (rd_exp),
        .cur_tag   (cur_tag),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    dram_dq_compare #(
        .DQ_W (DQ_W)
    ) u_cmp (
        .strobe   (rd_strobe),
        .exp_bit  (rd_exp),
        .dq       (dq_in),
        .mismatch (mismatch)
    );

    // Run control: start, phase/row stepping, failure capture, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= T_IDLE;
            phase_q <= PH_INIT;
            pass_q  <= 1'b0;
            row_q   <= '0;
            init_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            frow_q  <= '0;
            fph_q   <= '0;
        end else begin
            unique case (run_q)
                T_IDLE, T_DONE: begin
                    if (start) begin
                        run_q   <= T_RUN;
                        phase_q <= PH_INIT;
                        pass_q  <= 1'b0;
                        row_q   <= '0;
                        init_q  <= '0;
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        frow_q  <= '0;
                        fph_q   <= '0;
                    end
                end
                T_RUN: begin
                    if (mismatch) begin
                        run_q  <= T_DRAIN;
                        fail_q <= 1'b1;
                        frow_q <= cur_tag[ROW_BITS-1:0];
                        fph_q  <= cur_tag[TAG_W-1:ROW_BITS];
                    end else if (accept) begin
                        unique case (phase_q)
                            PH_INIT: begin
                                if (init_last) phase_q <= PH_FILL;
                                else           init_q  <= init_q + INIT_W'(1);
                            end
                            PH_FILL, PH_CBR: begin
                                row_q <= row_q + ROW_BITS'(1);
                                if (row_last)
                                    phase_q <= (phase_q == PH_FILL) ? PH_CBR : PH_VERIFY;
                            end
                            default: begin
                                row_q <= row_q + ROW_BITS'(1);
                                if (row_last) begin
                                    if (pass_q) run_q <= T_DRAIN;
                                    else begin
                                        pass_q  <= 1'b1;
                                        phase_q <= PH_FILL;
                                    end
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (mismatch && !fail_q) begin
                        fail_q <= 1'b1;
                        frow_q <= cur_tag[ROW_BITS-1:0];
                        fph_q  <= cur_tag[TAG_W-1:ROW_BITS];
                    end else if (eng_idle) begin
                        run_q  <= T_DONE;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign done       = done_q;
    assign fail       = fail_q;
    assign fail_row   = frow_q;
    assign fail_phase = fph_q;

endmodule

// File: rtl/dram_cbr_test_seq_chk.sv
// Protocol checker for the refresh counter test sequencer, bound to the
// top module. Observes ports only; keeps one saturating counter of clocks
// with RAS high to check the precharge window.
module dram_cbr_test_seq_chk #(
    parameter int ROW_BITS = 10,
    parameter int DQ_W     = 16,
    parameter int GAP_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [GAP_W-1:0]    cyc_gap,
    input logic                done,
    input logic                fail,
    input logic [ROW_BITS-1:0] fail_row,
    input logic [2:0]          fail_phase,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic                oe_n,
    input logic [DQ_W-1:0]     dq_out,
    input logic                dq_oe
);

    logic [GAP_W:0] hi_cnt;
    logic [GAP_W:0] gap_min;

    assign gap_min = (cyc_gap == '0) ? (GAP_W+1)'(1) : {1'b0, cyc_gap};

    // Count clocks with RAS high, saturating; starts saturated after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_cnt <= '1;
        else if (!ras_n)   hi_cnt <= '0;
        else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (ras_n && cas_n && we_n && oe_n && !dq_oe && !done && !fail));

    assert_cbr_double_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |=> cas_n ##1 !cas_n);

    assert_uniform_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dq_out == '0 || dq_out == '1));

    assert_quiet_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ras_n && cas_n && we_n && oe_n && !dq_oe));

    assert_precharge_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= gap_min));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(fail) && $stable(fail_row) &&
                              $stable(fail_phase) && done));

    assert_no_bus_fight_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

endmodule

bind dram_cbr_test_seq dram_cbr_test_seq_chk #(
    .ROW_BITS (ROW_BITS),
    .DQ_W     (DQ_W),
    .GAP_W    (GAP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cyc_gap    (cyc_gap),
    .done       (done),
    .fail       (fail),
    .fail_row   (fail_row),
    .fail_phase (fail_phase),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
);

// File: tb/dram_cbr_test_seq_test.sv
module dram_cbr_test_seq_test;

    localparam int CLK_P  = 10;
    localparam int ROWB   = 5;
    localparam int ROWS   = 1 << ROWB;
    localparam int COLB   = 10;
    localparam int DQ_W   = 16;
    localparam int GAP_W  = 4;
    localparam int ADDR_W = 10;
    localparam int NV     = 7;
    // {fault[2:0], gap[3:0], exp_fail, exp_phase[2:0], exp_row[4:0], exp_cycles[7:0]}
    localparam logic [23:0] VECS [NV] = '{
        {3'd0, 4'd2, 1'b0, 3'd0, 5'd0,  8'd128},
        {3'd0, 4'd0, 1'b0, 3'd0, 5'd0,  8'd128},
        {3'd0, 4'd5, 1'b0, 3'd0, 5'd0,  8'd128},
        {3'd1, 4'd1, 1'b1, 3'd2, 5'd31, 8'd32},
        {3'd2, 4'd3, 1'b1, 3'd3, 5'd5,  8'd38},
        {3'd3, 4'd2, 1'b1, 3'd2, 5'd2,  8'd3},
        {3'd4, 4'd1, 1'b1, 3'd7, 5'd12, 8'd109}
    };

    logic clk = 1'b0;
    logic rst_n, start;
    logic [COLB-1:0] col;
    logic [GAP_W-1:0] cyc_gap;
    logic done, fail;
    logic [ROWB-1:0] fail_row;
    logic [2:0] fail_phase;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [ADDR_W-1:0] addr;
    logic [DQ_W-1:0] dq_out, dq_in;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    dram_cbr_test_seq #(
        .ROW_BITS (ROWB), .COL_BITS (COLB), .DQ_W (DQ_W),
        .GAP_W (GAP_W), .INIT_CYCLES (8)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .col (col),
        .cyc_gap (cyc_gap), .done (done), .fail (fail),
        .fail_row (fail_row), .fail_phase (fail_phase),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .dq_out (dq_out), .dq_oe (dq_oe), .dq_in (dq_in)
    );

    // ---------------- DRAM behavioural model (sampled at negedge) -------
    logic pras = 1'b1, pcas = 1'b1;
    logic cbr_m = 1'b0, ro_m = 1'b0, colv_m = 1'b0, wflag_m = 1'b0;
    logic [ROWB-1:0] mrow = '0, ctr_m = '0;
    logic [DQ_W-1:0] wdat_m = '0, wv;
    logic [DQ_W-1:0] mem [ROWS];
    int n_ro, n_wr, n_wr1, n_rd, n_cbr, n_bad, n_colbad, cbr_run, hi_run, min_hi;
    int fault = 0;

    assign dq_in = (!ras_n && !cas_n && !oe_n && we_n && colv_m) ? mem[mrow] : '0;

    always @(negedge clk) begin
        if (pras === 1'b1 && ras_n === 1'b0) begin
            colv_m  = 1'b0;
            wflag_m = 1'b0;
            if (min_hi > hi_run) min_hi = hi_run;
            hi_run = 0;
            if (cas_n === 1'b0) begin cbr_m = 1'b1; ro_m = 1'b0; mrow = ctr_m; end
            else begin cbr_m = 1'b0; ro_m = 1'b1; mrow = addr[ROWB-1:0]; end
        end
        if (ras_n === 1'b0 && pcas === 1'b1 && cas_n === 1'b0) begin
            colv_m = 1'b1;
            ro_m   = 1'b0;
            if (addr !== ADDR_W'(col)) n_colbad++;
        end
        if (ras_n === 1'b0 && cas_n === 1'b0 && colv_m && we_n === 1'b0) begin
            wflag_m = 1'b1;
            wdat_m  = dq_out;
        end
        if (pras === 1'b0 && ras_n === 1'b1) begin
            if (wflag_m) begin
                if (wdat_m !== '0 && wdat_m !== '1) n_bad++;
                wv = wdat_m;
                if (fault == 2 && mrow == 5) wv[3] = 1'b0;
                if (fault == 3 && mrow == 9) wv[0] = 1'b1;
                if (!(fault == 4 && cbr_m && mrow == 12 && cbr_run >= ROWS))
                    mem[mrow] = wv;
            end
            if (ro_m) n_ro++;
            else if (cbr_m) begin
                n_cbr++;
                if (!wflag_m) n_bad++;
                ctr_m = ctr_m + ((fault == 1 && cbr_run == 4) ? ROWB'(2) : ROWB'(1));
                cbr_run++;
            end else if (wflag_m) begin
                n_wr++;
                if (wdat_m === '1) n_wr1++;
            end else if (colv_m) n_rd++;
        end
        if (ras_n === 1'b1) hi_run++;
        pras = ras_n;
        pcas = cas_n;
    end

    // ---------------- helpers -------------------------------------------
    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        n_ro = 0; n_wr = 0; n_wr1 = 0; n_rd = 0; n_cbr = 0;
        n_bad = 0; n_colbad = 0; cbr_run = 0;
        hi_run = 1000; min_hi = 1000;
        ctr_m = ROWB'(7);
        for (int r = 0; r < ROWS; r++) mem[r] = '0;
    endtask

    task automatic run_once(input int gap_i, input int fault_i, input bit mid_start);
        bit seen;
        cyc_gap = GAP_W'(gap_i);
        fault   = fault_i;
        clear_model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 40000; c++) begin
            @(negedge clk);
            if (mid_start && c == 300) start = 1'b1;
            if (mid_start && c == 301) start = 1'b0;
            if (done) begin seen = 1'b1; break; end
        end
        if (!seen) begin
            n_checks++; n_fail++;
            $display("FAIL R10 run did not finish actual=0 expected=1");
        end
    endtask

    task automatic check_pass_counts(input int gap_i, input string tag);
        chk({"R2 ras-only count ", tag}, n_ro, 8);
        chk({"R3 fill write count ", tag}, n_wr, 2*ROWS);
        chk({"R3 column mismatches ", tag}, n_colbad, 0);
        chk({"R4 counter cycle count ", tag}, n_cbr, 2*ROWS);
        chk({"R5 verify read count ", tag}, n_rd, 2*ROWS);
        chk({"R6 all-ones fill writes ", tag}, n_wr1, ROWS);
        chk({"R7 malformed writes ", tag}, n_bad, 0);
        chk({"R9 min RAS high clocks ", tag}, min_hi, (gap_i == 0) ? 1 : gap_i);
    endtask

    // ---------------- global watchdog -----------------------------------
    initial begin
        #(CLK_P * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // ---------------- main sequence -------------------------------------
    initial begin
        rst_n = 1'b0; start = 1'b0; col = 10'h2A5; cyc_gap = 4'd2;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 idle strobes", {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);
        chk("R1 done low", done, 0);
        chk("R1 fail low", fail, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [23:0] vec;
            vec = VECS[v];
            run_once(int'(vec[20:17]), int'(vec[23:21]), 1'b0);
            chk("R10 done raised", done, 1);
            chk("R8 fail flag", fail, int'(vec[16]));
            chk("R8 cycles before stop", n_cbr + n_rd, int'(vec[7:0]));
            if (vec[16]) begin
                chk("R8 fail phase", fail_phase, int'(vec[15:13]));
                chk("R8 fail row", fail_row, int'(vec[12:8]));
                chk("R8 pins quiet", {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);
                chk("R7 malformed writes", n_bad, 0);
            end else begin
                check_pass_counts(int'(vec[20:17]), "vec");
            end
        end

        // R10: result held while idle after a failing run
        repeat (20) @(negedge clk);
        chk("R10 done held", done, 1);
        chk("R10 fail row held", fail_row, 12);
        chk("R10 fail phase held", fail_phase, 7);

        // R10: start pulsed mid-run is ignored; rerun clears the failure
        col = 10'h01F;
        run_once(3, 0, 1'b1);
        chk("R10 rerun clears fail", fail, 0);
        check_pass_counts(3, "mid-start");

        // R1: reset in the middle of a run
        cyc_gap = 4'd1;
        clear_model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (400) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset strobes", {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);
        chk("R1 mid-run reset done", done, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk("R1 no activity without start", {ras_n, cas_n}, 2'b11);
        chk("R1 done stays low", done, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule